// File: doc/BRIEF.md
# Ping-Pong Scanline Pixel Buffer

This block holds two scanline buffers that swap roles at every new line. While the display side reads one buffer out pixel by pixel, the fill side paints sprite and fixed-layer pixels for the next line into the other. A select input sets which buffer is on which side. A change of that input is the line boundary: the read column returns to zero and the roles swap.

Each scanline buffer is made of an even-column bank and an odd-column bank. This lets one fill step store a pixel pair at any start column, odd or even. The fill side first loads a start column from the sprite X position. Each later step writes the next two columns and moves the pointer on by two. A write happens only for pixels whose opaque flag is set, so a transparent pixel leaves what lies under it. The display side returns one pixel per step. It clears each pixel it reads, so a buffer is empty again by the time it comes back to the fill side.

Top module: `scanline_pingpong`

## Requirements
- R1: With `line_sel_i` = 0, buffer 0 is read by the display side and buffer 1 is filled. With `line_sel_i` = 1 the roles are reversed.
- R2: On the first clock edge at which `line_sel_i` differs from its previous sampled value, the read column returns to 0. Both step strobes are ignored on that edge.
- R3: A fill step with `load_n_i` low sets the write column to `xpos_i` and writes no pixel.
- R4: A fill step with `load_n_i` high writes `pix_first_i` at write column c and `pix_second_i` at c+1, for even or odd c. It then advances the write column by 2.
- R5: A pixel whose opaque flag is 0 is not written, and the earlier content at that column is kept.
- R6: The write column wraps modulo 512. Columns 384 to 511 are off-line and never written.
- R7: A display step makes `pix_o` show the pixel at the read column on the clock after the step edge, and the read column advances by 1. `pix_o` holds its value between steps.
- R8: Each pixel read by the display side is cleared to 0 (transparent) in its buffer.
- R9: While `hblank_i` is high, both step strobes are ignored.
- R10: A display step taken once the read column has reached 384 gives `pix_o` = 0, and the read column stays at 384.
- R11: After reset, `pix_o` is 0 and every location of both buffers holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_sel_i | input | 1 | Buffer role select; a change marks a new line |
| hblank_i | input | 1 | Horizontal blanking; blocks both step strobes |
| fill_step_i | input | 1 | Fill-side step strobe |
| load_n_i | input | 1 | Low: a fill step loads the start column |
| xpos_i | input | 9 | Sprite start column |
| pix_first_i | input | 12 | Pixel for write column c |
| pix_second_i | input | 12 | Pixel for write column c+1 |
| opq_first_i | input | 1 | Opaque flag of pix_first_i |
| opq_second_i | input | 1 | Opaque flag of pix_second_i |
| disp_step_i | input | 1 | Display-side step strobe |
| pix_o | output | 12 | Current display pixel (palette and colour index) |

## Verification
A table of overlapping sprites is painted into one buffer and read back after a swap. The table uses full-opaque, checkerboard and empty masks, starting at both even and odd columns, including one run clipped at the right edge and one that wraps around to column 0. The result shows whether writes are gated by opacity, whether unaligned pairs land in the correct bank, and whether later sprites cover earlier ones only where they are opaque. Directed cases then strobe during blanking and during the swap edge, read past the end of the line, swap twice without filling to show that reads clear the buffer, and swap in the middle of a line to show that the read column returns to zero.

// File: rtl/lb_pkg.sv
package lb_pkg;

  localparam int unsigned LB_PIX_W    = 12;
  localparam int unsigned LB_LINE_LEN = 384;
  localparam int unsigned LB_PTR_W    = 9;

  // a column is on the line only below the line length
  function automatic bit col_visible(input int unsigned col, input int unsigned line_len);
    return col < line_len;
  endfunction

  // select 0: buffer 0 shown, buffer 1 filled
  function automatic bit disp_buf_of(input logic sel);
    return bit'(sel);
  endfunction

  function automatic bit fill_buf_of(input logic sel);
    return bit'(~sel);
  endfunction

endpackage

// File: rtl/lb_bank.sv
module lb_bank #(
  parameter int unsigned W     = 12,
  parameter int unsigned DEPTH = 192,
  parameter int unsigned AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // read returns the old word when the same row is cleared in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (re) rdata <= mem[raddr];
      if (we) mem[waddr] <= wdata;
    end
  end

  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (32'(waddr) < DEPTH)); // R6

endmodule

// File: rtl/lb_fill_ctrl.sv
module lb_fill_ctrl
  import lb_pkg::*;
#(
  parameter int unsigned PIX_W    = 12,
  parameter int unsigned PTR_W    = 9,
  parameter int unsigned LINE_LEN = 384,
  parameter int unsigned ROW_W    = PTR_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             load_n,
  input  logic [PTR_W-1:0] xpos,
  input  logic [PIX_W-1:0] pix_first,
  input  logic [PIX_W-1:0] pix_second,
  input  logic             opq_first,
  input  logic             opq_second,
  output logic             even_we,
  output logic [ROW_W-1:0] even_row,
  output logic [PIX_W-1:0] even_data,
  output logic             odd_we,
  output logic [ROW_W-1:0] odd_row,
  output logic [PIX_W-1:0] odd_data
);

  logic [PTR_W-1:0] wr_ptr_q;
  logic [PTR_W-1:0] col_next;
  logic             vis_first, vis_second;
  logic             lead_odd;
  logic             pair_go;

  assign col_next   = wr_ptr_q + PTR_W'(1);
  assign vis_first  = col_visible(32'(wr_ptr_q), LINE_LEN);
  assign vis_second = col_visible(32'(col_next), LINE_LEN);
  assign lead_odd   = wr_ptr_q[0];
  assign pair_go    = go & load_n;

  // an odd start column puts the first pixel in the odd bank and the second in the next even row
  always_comb begin
    if (lead_odd) begin
      even_we   = pair_go & opq_second & vis_second;
      even_row  = col_next[PTR_W-1:1];
      even_data = pix_second;
      odd_we    = pair_go & opq_first & vis_first;
      odd_row   = wr_ptr_q[PTR_W-1:1];
      odd_data  = pix_first;
    end else begin
      even_we   = pair_go & opq_first & vis_first;
      even_row  = wr_ptr_q[PTR_W-1:1];
      even_data = pix_first;
      odd_we    = pair_go & opq_second & vis_second;
      odd_row   = col_next[PTR_W-1:1];
      odd_data  = pix_second;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
    end else if (go) begin
      if (!load_n) wr_ptr_q <= xpos;
      else         wr_ptr_q <= wr_ptr_q + PTR_W'(2);
    end
  end

  AST_LOAD_TAKES_X: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !load_n) |=> (wr_ptr_q == $past(xpos))); // R3

  AST_LOAD_WRITES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !load_n) |-> !(even_we || odd_we)); // R3

  AST_PAIR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && load_n) |=> (wr_ptr_q == $past(wr_ptr_q) + PTR_W'(2))); // R4

  AST_IDLE_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(wr_ptr_q)); // R9

endmodule

// File: rtl/lb_disp_ctrl.sv
module lb_disp_ctrl
  import lb_pkg::*;
#(
  parameter int unsigned PTR_W    = 9,
  parameter int unsigned LINE_LEN = 384,
  parameter int unsigned ROW_W    = PTR_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_sel,
  input  logic             step,
  input  logic             hblank,
  output logic             swap,
  output logic             disp_go,
  output logic             rd_go,
  output logic             rd_odd,
  output logic [ROW_W-1:0] rd_row,
  output logic             disp_buf,
  output logic             fill_buf,
  output logic             src_valid_q,
  output logic             src_buf_q,
  output logic             src_odd_q
);

  localparam logic [PTR_W-1:0] END_COL = PTR_W'(LINE_LEN);

  logic             sel_q;
  logic [PTR_W-1:0] rd_ptr_q;
  logic             rd_vis;

  assign swap     = line_sel ^ sel_q;
  assign disp_go  = step & ~hblank & ~swap;
  assign rd_vis   = col_visible(32'(rd_ptr_q), LINE_LEN);
  assign rd_go    = disp_go & rd_vis;
  assign rd_odd   = rd_ptr_q[0];
  assign rd_row   = rd_ptr_q[PTR_W-1:1];
  assign disp_buf = disp_buf_of(line_sel);
  assign fill_buf = fill_buf_of(line_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q       <= 1'b0;
      rd_ptr_q    <= '0;
      src_valid_q <= 1'b0;
      src_buf_q   <= 1'b0;
      src_odd_q   <= 1'b0;
    end else begin
      sel_q <= line_sel;
      if (swap) begin
        rd_ptr_q <= '0;
      end else if (rd_go) begin
        rd_ptr_q <= rd_ptr_q + PTR_W'(1);
      end
      if (disp_go) begin
        src_valid_q <= rd_vis;
        if (rd_vis) begin
          src_buf_q <= disp_buf;
          src_odd_q <= rd_odd;
        end
      end
    end
  end

  AST_SWAP_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (rd_ptr_q == '0)); // R2

  AST_BLANK_FREEZES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (hblank && !swap) |=> $stable(rd_ptr_q)); // R9

  AST_READ_PTR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr_q <= END_COL); // R10

endmodule

// File: rtl/scanline_pingpong.sv
module scanline_pingpong
  import lb_pkg::*;
#(
  parameter int unsigned PIX_W    = LB_PIX_W,
  parameter int unsigned LINE_LEN = LB_LINE_LEN,
  parameter int unsigned PTR_W    = LB_PTR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_sel_i,
  input  logic             hblank_i,
  input  logic             fill_step_i,
  input  logic             load_n_i,
  input  logic [PTR_W-1:0] xpos_i,
  input  logic [PIX_W-1:0] pix_first_i,
  input  logic [PIX_W-1:0] pix_second_i,
  input  logic             opq_first_i,
  input  logic             opq_second_i,
  input  logic             disp_step_i,
  output logic [PIX_W-1:0] pix_o
);

  localparam int unsigned ROW_W = PTR_W - 1;
  localparam int unsigned DEPTH = LINE_LEN / 2;
  localparam int unsigned N_BUF = 2;
  localparam int unsigned N_PAR = 2;

  logic             swap, disp_go, rd_go, rd_odd;
  logic [ROW_W-1:0] rd_row;
  logic             disp_buf, fill_buf;
  logic             src_valid_q, src_buf_q, src_odd_q;
  logic             fill_go;
  logic             fe_we, fo_we;
  logic [ROW_W-1:0] fe_row, fo_row;
  logic [PIX_W-1:0] fe_data, fo_data;
  logic [PIX_W-1:0] bank_rd [N_BUF][N_PAR];

  lb_disp_ctrl #(
    .PTR_W(PTR_W), .LINE_LEN(LINE_LEN), .ROW_W(ROW_W)
  ) i_disp (
    .clk(clk), .rst_n(rst_n), .line_sel(line_sel_i), .step(disp_step_i),
    .hblank(hblank_i), .swap(swap), .disp_go(disp_go), .rd_go(rd_go),
    .rd_odd(rd_odd), .rd_row(rd_row), .disp_buf(disp_buf), .fill_buf(fill_buf),
    .src_valid_q(src_valid_q), .src_buf_q(src_buf_q), .src_odd_q(src_odd_q)
  );

  assign fill_go = fill_step_i & ~hblank_i & ~swap;

  lb_fill_ctrl #(
    .PIX_W(PIX_W), .PTR_W(PTR_W), .LINE_LEN(LINE_LEN), .ROW_W(ROW_W)
  ) i_fill (
    .clk(clk), .rst_n(rst_n), .go(fill_go), .load_n(load_n_i), .xpos(xpos_i),
    .pix_first(pix_first_i), .pix_second(pix_second_i),
    .opq_first(opq_first_i), .opq_second(opq_second_i),
    .even_we(fe_we), .even_row(fe_row), .even_data(fe_data),
    .odd_we(fo_we), .odd_row(fo_row), .odd_data(fo_data)
  );

  for (genvar k = 0; k < int'(N_BUF); k++) begin : g_buf
    for (genvar q = 0; q < int'(N_PAR); q++) begin : g_par
      logic             fill_hit, clr_hit;
      logic             we;
      logic [ROW_W-1:0] waddr;
      logic [PIX_W-1:0] wdata;

      always_comb begin
        fill_hit = (fill_buf == 1'(k)) && ((q == 0) ? fe_we : fo_we);
        clr_hit  = rd_go && (disp_buf == 1'(k)) && (rd_odd == 1'(q));
        we       = fill_hit | clr_hit;
        if (fill_hit) begin
          waddr = (q == 0) ? fe_row : fo_row;
          wdata = (q == 0) ? fe_data : fo_data;
        end else begin
          waddr = rd_row;
          wdata = '0;
        end
      end

      lb_bank #(
        .W(PIX_W), .DEPTH(DEPTH), .AW(ROW_W)
      ) i_bank (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
        .re(clr_hit), .raddr(rd_row), .rdata(bank_rd[k][q])
      );

      AST_ONE_SIDE_PER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_hit && clr_hit)); // R1
    end
  end

  assign pix_o = src_valid_q ? bank_rd[src_buf_q][src_odd_q] : '0;

  AST_PIX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_go |=> $stable(pix_o)); // R7

  AST_END_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_go && !rd_go) |=> (pix_o == '0)); // R10

  AST_BLANK_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_i |-> !(fe_we || fo_we)); // R9

endmodule

// File: tb/test_scanline_pingpong.sv
module test_scanline_pingpong;

  localparam int CLK_PERIOD = 10;
  localparam int LINE       = 384;
  localparam int WDOG       = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_sel_i = 1'b0, hblank_i = 1'b0, fill_step_i = 1'b0, load_n_i = 1'b1;
  logic [8:0]  xpos_i = '0;
  logic [11:0] pix_first_i = '0, pix_second_i = '0;
  logic        opq_first_i = 1'b0, opq_second_i = 1'b0, disp_step_i = 1'b0;
  logic [11:0] pix_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [11:0] model [LINE];

  // x[40:32] colour[31:20] pairs[19:16] opaque mask[15:0] (bit k = pixel k)
  localparam logic [40:0] SPRITES [8] = '{
    {9'd0,   12'h110, 4'd8, 16'hFFFF},
    {9'd5,   12'h220, 4'd8, 16'h0F0F},
    {9'd100, 12'h330, 4'd8, 16'hFFFF},
    {9'd107, 12'h440, 4'd8, 16'hAAAA},
    {9'd379, 12'h550, 4'd4, 16'hFFFF},
    {9'd509, 12'h660, 4'd4, 16'hFFFF},
    {9'd200, 12'h770, 4'd8, 16'h0000},
    {9'd201, 12'h880, 4'd2, 16'h0005}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  scanline_pingpong i_scanline_pingpong (
    .clk(clk), .rst_n(rst_n), .line_sel_i(line_sel_i), .hblank_i(hblank_i),
    .fill_step_i(fill_step_i), .load_n_i(load_n_i), .xpos_i(xpos_i),
    .pix_first_i(pix_first_i), .pix_second_i(pix_second_i),
    .opq_first_i(opq_first_i), .opq_second_i(opq_second_i),
    .disp_step_i(disp_step_i), .pix_o(pix_o)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge; one rising edge lies between
  task automatic fill_cycle(input logic blank, input logic ld_n, input logic [8:0] x,
                            input logic [11:0] p0, input logic [11:0] p1,
                            input logic o0, input logic o1);
    hblank_i = blank; fill_step_i = 1'b1; load_n_i = ld_n; xpos_i = x;
    pix_first_i = p0; pix_second_i = p1; opq_first_i = o0; opq_second_i = o1;
    @(negedge clk);
    fill_step_i = 1'b0; hblank_i = 1'b0; load_n_i = 1'b1;
  endtask

  task automatic read_px(input logic blank, output logic [11:0] v);
    hblank_i = blank; disp_step_i = 1'b1;
    @(negedge clk);
    disp_step_i = 1'b0; hblank_i = 1'b0;
    v = pix_o;
  endtask

  task automatic set_sel(input logic v, input logic strobe);
    line_sel_i = v; disp_step_i = strobe; fill_step_i = strobe;
    load_n_i = 1'b0; xpos_i = 9'd3;
    @(negedge clk);
    disp_step_i = 1'b0; fill_step_i = 1'b0; load_n_i = 1'b1;
  endtask

  task automatic draw(input logic [40:0] s);
    int x, np;
    logic [11:0] colr;
    logic [15:0] m;
    x = int'(s[40:32]); colr = s[31:20]; np = int'(s[19:16]); m = s[15:0];
    // load step drives opaque junk: it must not land (R3)
    fill_cycle(1'b0, 1'b0, s[40:32], 12'hABC, 12'hABC, 1'b1, 1'b1);
    for (int p = 0; p < np; p++) begin
      fill_cycle(1'b0, 1'b1, 9'd0, colr | 12'(2*p), colr | 12'(2*p+1), m[2*p], m[2*p+1]);
      for (int h = 0; h < 2; h++) begin
        int col;
        col = (x + 2*p + h) % 512;
        if (m[2*p+h] && col < LINE) model[col] = colr | 12'(2*p+h);
      end
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [11:0] v, prev;
    for (int i = 0; i < LINE; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R11 pix_o after reset", pix_o, 12'h000);

    // select 0: buffer 0 displayed, cleared by reset
    for (int i = 0; i < 3; i++) begin
      read_px(1'b0, v);
      check("R11 reset buffer empty", v, 12'h000);
    end

    // table walk: paint buffer 1
    for (int s = 0; s < 8; s++) draw(SPRITES[s]);
    // fill step during blanking at column 205 is dropped (R9)
    fill_cycle(1'b1, 1'b1, 9'd0, 12'hDDD, 12'hDDD, 1'b1, 1'b1);

    // swap with both strobes high: they are ignored (R2)
    set_sel(1'b1, 1'b1);
    for (int c = 0; c < LINE; c++) begin
      if (c == 10) begin
        prev = pix_o;
        read_px(1'b1, v);
        check("R9 display step in blanking", v, prev);
      end
      read_px(1'b0, v);
      check("R1 R4 R5 R6 R7 line readout", v, model[c]);
    end
    for (int i = 0; i < 2; i++) begin
      read_px(1'b0, v);
      check("R10 past end of line", v, 12'h000);
    end

    // swap away and back without filling: buffer 1 was cleared by reading
    set_sel(1'b0, 1'b0);
    read_px(1'b0, v);
    check("R11 buffer 0 still empty", v, 12'h000);
    set_sel(1'b1, 1'b0);
    for (int i = 0; i < 16; i++) begin
      read_px(1'b0, v);
      check("R8 read clears buffer", v, 12'h000);
    end

    // mid-line swap: paint buffer 0, read three, swap twice, read restarts at 0
    fill_cycle(1'b0, 1'b0, 9'd0, 12'h000, 12'h000, 1'b0, 1'b0);
    for (int p = 0; p < 4; p++)
      fill_cycle(1'b0, 1'b1, 9'd0, 12'h900 | 12'(2*p), 12'h900 | 12'(2*p+1), 1'b1, 1'b1);
    set_sel(1'b0, 1'b0);
    for (int c = 0; c < 3; c++) begin
      read_px(1'b0, v);
      check("R4 second buffer readout", v, 12'h900 | 12'(c));
    end
    set_sel(1'b1, 1'b0);
    set_sel(1'b0, 1'b0);
    for (int c = 0; c < 3; c++) begin
      read_px(1'b0, v);
      check("R2 rewound to cleared column", v, 12'h000);
    end
    read_px(1'b0, v);
    check("R2 first unread column", v, 12'h903);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule